// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the order in which the columns of an open DRAM row are visited during a read or write burst. A command decoder loads it with a 9-bit starting column, a burst-length code and an ordering choice. After that it presents one column per clock while its step enable is high. It marks the final beat of a fixed-length burst and gives a one-cycle completion pulse when the burst ends.

Two orderings are supported. The linear order counts upward and wraps inside the aligned block of burst length. The interleaved order XORs the beat number into the low column bits. A full-row mode walks the whole row and wraps from the top column back to zero. It runs until a stop request arrives or a fresh command reloads it. A new load on any cycle abandons the burst in flight, and a stop request ends it at once.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `done`, `last` and `illegal` are 0.
- R2: In the cycle after `start` is high, `busy` is 1 and `col` equals the loaded `start_col`. This holds whether or not a burst was already running.
- R3: With `order`=0 (linear), `len_sel` 0,1,2,3 selects 1,2,4,8 beats. Beat n shows the low log2(length) bits of `start_col`+n, wrapped inside the aligned block, and the upper bits are unchanged.
- R4: With `order`=1 (interleaved), beat n shows `start_col` XOR n within the aligned block of the selected length.
- R5: With `full_page`=1 and `order`=0, beat n shows (`start_col`+n) mod 512, wrapping from 511 to 0. `last` stays 0 and the burst never ends on its own.
- R6: A load with `full_page`=1 and `order`=1 raises `illegal` from the next cycle until the next load. That burst runs as an 8-beat interleaved burst.
- R7: `last` is 1 exactly on the final beat of a fixed-length burst. Stepping past it drops `busy` and raises `done` in the next cycle.
- R8: `stop` while busy, without `start`, makes `busy` 0 and `done` 1 in the next cycle.
- R9: While busy with `step_en`, `start` and `stop` all low, `col` and `busy` hold their values.
- R10: When `start` and `stop` are high together, the load wins and the new burst begins.
- R11: `done` lasts a single cycle. `stop` while idle leaves `done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new burst (read or write command) |
| start_col | input | 9 | First column of the burst |
| len_sel | input | 2 | Length code: 0=1, 1=2, 2=4, 3=8 beats |
| full_page | input | 1 | Whole-row burst request |
| order | input | 1 | 0 linear, 1 interleaved |
| stop | input | 1 | Burst-stop request |
| step_en | input | 1 | Advance one beat at this edge |
| col | output | 9 | Current column |
| busy | output | 1 | Burst in progress |
| last | output | 1 | Current beat is the final one |
| done | output | 1 | One-cycle pulse after a burst ends |
| illegal | output | 1 | Full-row interleaved request was made |

## Verification
The hardest cases to reach from the ports are the ones where commands collide at exact beat positions. These include a reload landing mid-burst, a load and a stop in the same cycle, and a stop on the same edge as a stalled step. The bench reaches them with directed sequences that count negative edges from the load. It then drives the second command on a chosen beat, so the expected column on every following beat can be worked out by hand. The full-row wrap past column 511 is reached by loading column 509 and stepping five times. The illegal combination is exercised by loading it directly and stepping it to its natural end.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int COL_W   = 9;
    localparam int LSEL_W  = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic   full;
        logic   illegal;
        order_e ord;
    } burst_flags_t;

    function automatic logic [COL_W-1:0] len_mask(input logic [LSEL_W-1:0] sel);
        logic [COL_W-1:0] one;
        one = {{(COL_W-1){1'b0}}, 1'b1};
        return (one << sel) - one;
    endfunction

    function automatic logic [COL_W-1:0] map_col(
        input logic [COL_W-1:0] base,
        input logic [COL_W-1:0] beat,
        input logic [COL_W-1:0] mask,
        input order_e           ord
    );
        logic [COL_W-1:0] low;
        if (ord == ORD_XOR)
            low = base ^ beat;
        else
            low = base + beat;
        return (base & ~mask) | (low & mask);
    endfunction

endpackage

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
    import burst_col_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic [LSEL_W-1:0] len_sel,
    input  logic              full_req,
    input  order_e            ord,
    output logic [CW-1:0]     mask,
    output burst_flags_t      flags
);
    localparam logic [LSEL_W-1:0] SEL_MAX = {LSEL_W{1'b1}};

    logic bad_combo;
    logic [LSEL_W-1:0] eff_sel;

    always_comb begin
        bad_combo = full_req && (ord == ORD_XOR);
        eff_sel   = bad_combo ? SEL_MAX : len_sel;
        if (full_req && !bad_combo)
            mask = {CW{1'b1}};
        else
            mask = CW'(len_mask(eff_sel));
        flags.full    = full_req && !bad_combo;
        flags.illegal = bad_combo;
        flags.ord     = ord;
    end

endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
    import burst_col_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          step_en,
    input  logic [CW-1:0] start_col,
    input  logic [CW-1:0] mask_in,
    input  burst_flags_t  flags_in,
    output logic [CW-1:0] base_q,
    output logic [CW-1:0] beat_q,
    output logic [CW-1:0] mask_q,
    output burst_flags_t  flags_q,
    output logic          busy_q,
    output logic          last,
    output logic          done_q
);
    localparam logic [CW-1:0] BEAT_ONE = {{(CW-1){1'b0}}, 1'b1};

    always_comb begin
        last = busy_q && !flags_q.full && (beat_q == mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            flags_q <= '{full: 1'b0, illegal: 1'b0, ord: ORD_LINEAR};
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                base_q  <= start_col;
                beat_q  <= '0;
                mask_q  <= mask_in;
                flags_q <= flags_in;
                busy_q  <= 1'b1;
            end else if (busy_q && stop) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else if (busy_q && step_en) begin
                beat_q <= beat_q + BEAT_ONE;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map
    import burst_col_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] beat,
    input  logic [CW-1:0] mask,
    input  order_e        ord,
    output logic [CW-1:0] col
);
    logic [CW-1:0] lin_low;
    logic [CW-1:0] xor_low;

    for (genvar b = 0; b < CW; b++) begin : g_bit
        always_comb begin
            col[b] = mask[b] ? ((ord == ORD_XOR) ? xor_low[b] : lin_low[b]) : base[b];
        end
    end

    always_comb begin
        lin_low = base + beat;
        xor_low = base ^ beat;
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CW-1:0]     start_col,
    input  logic [LSEL_W-1:0] len_sel,
    input  logic              full_page,
    input  logic              order,
    input  logic              stop,
    input  logic              step_en,
    output logic [CW-1:0]     col,
    output logic              busy,
    output logic              last,
    output logic              done,
    output logic              illegal
);
    logic [CW-1:0] dec_mask;
    burst_flags_t  dec_flags;
    logic [CW-1:0] base_q;
    logic [CW-1:0] beat_q;
    logic [CW-1:0] mask_q;
    burst_flags_t  flags_q;

    bcg_cfg_decode #(.CW(CW)) u_dec (
        .len_sel  (len_sel),
        .full_req (full_page),
        .ord      (order_e'(order)),
        .mask     (dec_mask),
        .flags    (dec_flags)
    );

    bcg_beat_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .step_en   (step_en),
        .start_col (start_col),
        .mask_in   (dec_mask),
        .flags_in  (dec_flags),
        .base_q    (base_q),
        .beat_q    (beat_q),
        .mask_q    (mask_q),
        .flags_q   (flags_q),
        .busy_q    (busy),
        .last      (last),
        .done_q    (done)
    );

    bcg_col_map #(.CW(CW)) u_map (
        .base (base_q),
        .beat (beat_q),
        .mask (mask_q),
        .ord  (flags_q.ord),
        .col  (col)
    );

    always_comb begin
        illegal = flags_q.illegal;
    end

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [CW-1:0] start_col,
    input logic          full_page,
    input logic          order,
    input logic          stop,
    input logic          step_en,
    input logic [CW-1:0] col,
    input logic          busy,
    input logic          last,
    input logic          done,
    input logic          illegal
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !last && !illegal));

    assert_load_col_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && col == $past(start_col)));

    assert_fullpage_no_last_R5: assert property (@(posedge clk) disable iff (rst)
        (start && full_page && !order) |=> !last);

    assert_illegal_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (start && full_page && order) |=> illegal);

    assert_end_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (last && step_en && !start && !stop) |=> (!busy && done));

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && stop && !start) |=> (!busy && done));

    assert_hold_col_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_en && !start && !stop) |=> (busy && $stable(col)));

    assert_start_beats_stop_R10: assert property (@(posedge clk) disable iff (rst)
        (start && stop) |=> (busy && !done));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_no_done_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !done);

endmodule

bind burst_col_gen bcg_checker #(.CW(CW)) u_bcg_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_col (start_col),
    .full_page (full_page),
    .order     (order),
    .stop      (stop),
    .step_en   (step_en),
    .col       (col),
    .busy      (busy),
    .last      (last),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [1:0] len_sel = '0;
    logic       full_page = 1'b0;
    logic       order = 1'b0;
    logic       stop = 1'b0;
    logic       step_en = 1'b0;
    logic [8:0] col;
    logic       busy, last, done, illegal;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_sel(len_sel), .full_page(full_page), .order(order),
        .stop(stop), .step_en(step_en), .col(col), .busy(busy),
        .last(last), .done(done), .illegal(illegal)
    );

    localparam int NV = 7;
    localparam int V_COL [NV] = '{5, 5, 267, 267, 511, 6, 510};
    localparam int V_LEN [NV] = '{2, 2, 3, 3, 1, 0, 3};
    localparam int V_ORD [NV] = '{0, 1, 0, 1, 0, 0, 1};
    localparam int V_N   [NV] = '{4, 4, 8, 8, 2, 1, 8};
    localparam int V_EXP [NV][8] = '{
        '{5, 6, 7, 4, 0, 0, 0, 0},
        '{5, 4, 7, 6, 0, 0, 0, 0},
        '{267, 268, 269, 270, 271, 264, 265, 266},
        '{267, 266, 265, 264, 271, 270, 269, 268},
        '{511, 510, 0, 0, 0, 0, 0, 0},
        '{6, 0, 0, 0, 0, 0, 0, 0},
        '{510, 511, 508, 509, 506, 507, 504, 505}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start = 1'b0; stop = 1'b0; step_en = 1'b0; full_page = 1'b0;
    endtask

    task automatic load(input int c, input int l, input int o, input bit fp);
        @(negedge clk);
        start = 1'b1; start_col = 9'(c); len_sel = 2'(l);
        order = o[0]; full_page = fp; stop = 1'b0; step_en = 1'b1;
        @(negedge clk);
        start = 1'b0; full_page = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 illegal", int'(illegal), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 last", int'(last), 0);

        // R3 R4 R7: table of bursts
        for (int v = 0; v < NV; v++) begin
            load(V_COL[v], V_LEN[v], V_ORD[v], 1'b0);
            for (int b = 0; b < V_N[v]; b++) begin
                chk(V_ORD[v] == 0 ? "R3 col" : "R4 col", int'(col), V_EXP[v][b]);
                chk("R7 last", int'(last), (b == V_N[v] - 1) ? 1 : 0);
                @(negedge clk);
            end
            chk("R7 busy end", int'(busy), 0);
            chk("R7 done", int'(done), 1);
            step_en = 1'b0;
            @(negedge clk);
            chk("R11 done pulse", int'(done), 0);
        end

        // R5: full page wraps past 511 then R8 stop
        load(509, 0, 0, 1'b1);
        for (int b = 0; b < 5; b++) begin
            chk("R5 col", int'(col), (509 + b) % 512);
            chk("R5 last", int'(last), 0);
            @(negedge clk);
        end
        chk("R5 busy", int'(busy), 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R8 busy", int'(busy), 0);
        chk("R8 done", int'(done), 1);
        step_en = 1'b0;

        // R6: interleaved full page flagged, runs 8 beats
        load(3, 0, 1, 1'b1);
        chk("R6 illegal", int'(illegal), 1);
        for (int b = 0; b < 8; b++) begin
            chk("R6 col", int'(col), 3 ^ b);
            @(negedge clk);
        end
        chk("R6 end", int'(busy), 0);
        step_en = 1'b0;
        load(8, 1, 0, 1'b0);
        chk("R6 cleared", int'(illegal), 0);

        // R9: stall holds column
        load(20, 2, 0, 1'b0);
        @(negedge clk);
        chk("R9 col", int'(col), 21);
        step_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 held col", int'(col), 21);
        chk("R9 held busy", int'(busy), 1);
        step_en = 1'b1;
        @(negedge clk);
        chk("R9 resume", int'(col), 22);

        // R2: reload mid-burst
        start = 1'b1; start_col = 9'd100; len_sel = 2'd3; order = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 reload col", int'(col), 100);
        chk("R2 reload busy", int'(busy), 1);
        @(negedge clk);
        chk("R2 next beat", int'(col), 101);

        // R10: start and stop together
        start = 1'b1; stop = 1'b1; start_col = 9'd40; len_sel = 2'd1; order = 1'b0;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk("R10 busy", int'(busy), 1);
        chk("R10 col", int'(col), 40);
        chk("R10 done", int'(done), 0);
        @(negedge clk);
        @(negedge clk);
        idle_inputs();

        // R11: stop while idle
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R11 idle stop done", int'(done), 0);
        chk("R11 idle stop busy", int'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule